// File: doc/BRIEF.md
# Mailbox-Triggered Notification Queue

This unit sits on the shared bus of a two-processor system and gives each processor a hardware queue of short notification codes. Each processor owns a 128-byte mailbox window. Any 32-bit write that falls inside a window leaves the bus write untouched on its way to memory. As a side effect, the most significant nibble of the written word is appended to the queue that belongs to that window. A sender therefore places its message in the receiver's mailbox, and the receiver is told about it through its queue.

Each queue drives its owner's interrupt line while it holds entries, gated by a per-processor enable bit. Both processors drain their queues through one shared pop address. The unit uses the requester-ID bit to choose which queue a read is served from. If a queue is already full, a further write to its window is dropped and a sticky overflow flag is raised for that processor. The processor clears the flag through its control register.

The default address map is:

| Item | Address |
|---|---|
| Mailbox X | 0x1000 to 0x107F |
| Mailbox Y | 0x1080 to 0x10FF |
| Pop address | 0x2000 |
| Control address | 0x2004 |

Requester ID 0 is processor X and requester ID 1 is processor Y.

Top module: `notif_queue_unit`

## Requirements
- R1: After reset the following are all 0: irq_x, irq_y, ovf_x, ovf_y and rdata. Both queues are empty and both interrupt enables are off.
- R2: A write (we=1) to any byte address from 0x1000 to 0x107F pushes wdata[31:28] into queue X. A write to any address from 0x1080 to 0x10FF pushes into queue Y. A write to any address outside both windows pushes into neither queue.
- R3: Entries leave a queue in the order in which their writes arrived, whatever their addresses within the window.
- R4: A read (re=1) of 0x2000 removes the head of the requester's own queue (req_id 0 selects X, 1 selects Y). The head value appears in rdata[3:0], with rdata[31:4]=0, on the clock edge that samples the read. The other queue is not touched.
- R5: A read of 0x2000 when the requester's queue is empty returns 0 and leaves that queue empty.
- R6: Each irq output is high exactly when its processor's enable bit is 1 and its queue holds at least one entry. The output follows the clock edge that changes either condition.
- R7: A write to 0x2004 loads wdata[0] into the requester's interrupt enable. If wdata[1] is 1, the same write also clears the requester's overflow flag. The other processor's settings are not changed.
- R8: Each queue holds 64 entries without loss. A write to a full queue's window is dropped and sets that queue's ovf output, which stays at 1 until it is cleared as described in R7.
- R9: mem_we, mem_addr and mem_wdata equal we, addr and wdata in the same cycle, with no change.
- R10: A read of any address other than 0x2000 returns 0 in rdata and removes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 16 | Byte address of the bus access |
| wdata | input | 32 | Write data |
| we | input | 1 | Write strobe |
| re | input | 1 | Read strobe |
| req_id | input | 1 | Requesting processor (0 = X, 1 = Y) |
| rdata | output | 32 | Registered read data |
| irq_x | output | 1 | Interrupt to processor X |
| irq_y | output | 1 | Interrupt to processor Y |
| ovf_x | output | 1 | Sticky overflow flag of queue X |
| ovf_y | output | 1 | Sticky overflow flag of queue Y |
| mem_we | output | 1 | Write strobe passed on to the mailbox memory |
| mem_addr | output | 16 | Address passed on to the mailbox memory |
| mem_wdata | output | 32 | Write data passed on to the mailbox memory |

## Verification
Results are due at three different times:

- **Mailbox pass-through:** combinational, so the bench compares the memory-side outputs one time step after driving the inputs, within the same cycle.
- **Pops, overflow flags and interrupts:** each is decided on the single clock edge that samples the strobe, and each is registered or built from registered state, so it is valid one edge after the access.
- **Pushes:** visible only through a later pop, which again has one edge of latency.

The bench drives every access on a falling edge and samples on the next falling edge, half a period after the deciding rising edge, so each check reads the result exactly one edge after its stimulus.

// File: rtl/nq_pkg.sv
// Package: shared types and constants of the notification queue unit.
// Assumes exactly two processors, indexed by the requester-ID bit.
package nq_pkg;
    localparam int NUM_PROC = 2;

    typedef enum logic {
        PROC_X = 1'b0,
        PROC_Y = 1'b1
    } proc_e;

    // One-hot per-processor strobes produced by the address decoder
    typedef struct packed {
        logic [NUM_PROC-1:0] push;
        logic [NUM_PROC-1:0] pop;
        logic [NUM_PROC-1:0] ctrl;
        logic                rd_pop;
    } dec_t;
endpackage

// File: rtl/nq_decode.sv
// Module: nq_decode
// Turns one bus access into per-queue push, pop and control strobes.
// Assumes each window base is aligned to the window size and that the
// windows, the pop address and the control address do not overlap.
module nq_decode
    import nq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int WIN_BYTES = 128,
    parameter logic [ADDR_W-1:0] X_BASE = 16'h1000,
    parameter logic [ADDR_W-1:0] Y_BASE = 16'h1080,
    parameter logic [ADDR_W-1:0] POP_ADDR = 16'h2000,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h2004
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              re,
    input  logic              req_id,
    output dec_t              dec
);
    localparam int WIN_LSB = $clog2(WIN_BYTES);

    logic [NUM_PROC-1:0] win_hit;
    logic [NUM_PROC-1:0] req_oh;
    logic                pop_hit;
    logic                ctrl_hit;

    // Window match on the bits above the window offset
    always_comb begin
        win_hit[PROC_X] = (addr[ADDR_W-1:WIN_LSB] == X_BASE[ADDR_W-1:WIN_LSB]);
        win_hit[PROC_Y] = (addr[ADDR_W-1:WIN_LSB] == Y_BASE[ADDR_W-1:WIN_LSB]);
    end

    // Requester one-hot and exact-address matches
    always_comb begin
        req_oh   = (req_id == PROC_Y) ? 2'b10 : 2'b01;
        pop_hit  = (addr == POP_ADDR);
        ctrl_hit = (addr == CTRL_ADDR);
    end

    // Strobe assembly
    always_comb begin
        dec.push   = we ? win_hit : '0;
        dec.pop    = (re && pop_hit) ? req_oh : '0;
        dec.ctrl   = (we && ctrl_hit) ? req_oh : '0;
        dec.rd_pop = re && pop_hit;
    end
endmodule

// File: rtl/nq_fifo.sv
// Module: nq_fifo
// Circular FIFO of nibble-wide notification codes with an occupancy count.
// A push into a full queue is refused unless a pop frees a slot in the same
// cycle; the refused push is reported on drop. A pop of an empty queue does
// nothing. The head reads as zero when the queue is empty.
module nq_fifo #(
    parameter int DEPTH = 64,
    parameter int W = 4,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] cnt,
    output logic          drop
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          empty;
    logic          full;
    logic          do_push;
    logic          do_pop;

    // Accept/refuse decisions
    always_comb begin
        empty   = (cnt == '0);
        full    = (cnt == CW'(DEPTH));
        do_pop  = pop && !empty;
        do_push = push && (!full || do_pop);
        drop    = push && !do_push;
        head    = empty ? '0 : mem[rd_ptr];
    end

    // Storage write, no reset needed on data
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and count update with wrap at DEPTH
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/nq_irq.sv
// Module: nq_irq
// Per-processor interrupt enable and sticky overflow flag.
// Assumes ctrl_wr is already qualified by requester, so only the owning
// processor can change its own enable or clear its own flag. A drop in the
// same cycle as a clear keeps the flag set.
module nq_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic [1:0] ctrl_bits,
    input  logic       drop,
    input  logic       nonempty,
    output logic       irq,
    output logic       ovf
);
    logic en;

    // Enable register loaded from control bit 0
    always_ff @(posedge clk) begin
        if (!rst_n)       en <= 1'b0;
        else if (ctrl_wr) en <= ctrl_bits[0];
    end

    // Sticky overflow: set by a drop, cleared by control bit 1
    always_ff @(posedge clk) begin
        if (!rst_n)                       ovf <= 1'b0;
        else if (drop)                    ovf <= 1'b1;
        else if (ctrl_wr && ctrl_bits[1]) ovf <= 1'b0;
    end

    // Level interrupt while enabled and pending
    always_comb irq = en && nonempty;
endmodule

// File: rtl/notif_queue_unit.sv
// Module: notif_queue_unit
// Top level: decodes bus accesses, fills one queue per processor from the
// upper nibble of mailbox writes, steers pops by requester ID, and drives
// masked level interrupts. The memory write path is passed through as-is.
// Assumes at most one access (read or write) is presented per cycle.
module notif_queue_unit
    import nq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH = 64,
    parameter int NIB_W = 4,
    parameter int WIN_BYTES = 128,
    parameter logic [ADDR_W-1:0] X_BASE = 16'h1000,
    parameter logic [ADDR_W-1:0] Y_BASE = 16'h1080,
    parameter logic [ADDR_W-1:0] POP_ADDR = 16'h2000,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h2004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    input  logic              re,
    input  logic              req_id,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_x,
    output logic              irq_y,
    output logic              ovf_x,
    output logic              ovf_y,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    localparam int CW = $clog2(DEPTH + 1);

    dec_t             dec;
    logic [NIB_W-1:0] head [NUM_PROC];
    logic [CW-1:0]    cnt  [NUM_PROC];
    logic [NUM_PROC-1:0] drop;
    logic [NUM_PROC-1:0] irq_v;
    logic [NUM_PROC-1:0] ovf_v;
    logic [CW-1:0]    cnt_x;
    logic [CW-1:0]    cnt_y;

    nq_decode #(
        .ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES),
        .X_BASE(X_BASE), .Y_BASE(Y_BASE),
        .POP_ADDR(POP_ADDR), .CTRL_ADDR(CTRL_ADDR)
    ) u_dec (
        .addr(addr), .we(we), .re(re), .req_id(req_id), .dec(dec)
    );

    for (genvar g = 0; g < NUM_PROC; g++) begin : g_proc
        nq_fifo #(.DEPTH(DEPTH), .W(NIB_W)) u_fifo (
            .clk(clk), .rst_n(rst_n),
            .push(dec.push[g]), .din(wdata[DATA_W-1 -: NIB_W]),
            .pop(dec.pop[g]), .head(head[g]), .cnt(cnt[g]), .drop(drop[g])
        );
        nq_irq u_irq (
            .clk(clk), .rst_n(rst_n),
            .ctrl_wr(dec.ctrl[g]), .ctrl_bits(wdata[1:0]),
            .drop(drop[g]), .nonempty(cnt[g] != '0),
            .irq(irq_v[g]), .ovf(ovf_v[g])
        );
    end

    // Registered read data: steered head on a pop, zero on any other read
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= dec.rd_pop ? DATA_W'(head[req_id]) : '0;
    end

    // Output mapping and memory pass-through
    always_comb begin
        irq_x     = irq_v[PROC_X];
        irq_y     = irq_v[PROC_Y];
        ovf_x     = ovf_v[PROC_X];
        ovf_y     = ovf_v[PROC_Y];
        cnt_x     = cnt[PROC_X];
        cnt_y     = cnt[PROC_Y];
        mem_we    = we;
        mem_addr  = addr;
        mem_wdata = wdata;
    end
endmodule

// File: rtl/nq_checker.sv
// Module: nq_checker
// Temporal checks of the notification queue unit, attached by bind.
// Window matching is recomputed here from the address map parameters.
module nq_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH = 64,
    parameter int WIN_BYTES = 128,
    parameter logic [ADDR_W-1:0] X_BASE = 16'h1000,
    parameter logic [ADDR_W-1:0] POP_ADDR = 16'h2000,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h2004,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              we,
    input logic              re,
    input logic              req_id,
    input logic [DATA_W-1:0] rdata,
    input logic              irq_x,
    input logic              irq_y,
    input logic              ovf_x,
    input logic [CW-1:0]     cnt_x,
    input logic [CW-1:0]     cnt_y
);
    logic in_x;
    logic pop_x;
    always_comb begin
        in_x  = (addr >= X_BASE) && (addr < X_BASE + ADDR_W'(WIN_BYTES));
        pop_x = re && (addr == POP_ADDR) && !req_id;
    end

    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_x <= CW'(DEPTH)) && (cnt_y <= CW'(DEPTH)));

    p_irq_x_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_x |-> (cnt_x != '0));

    p_irq_y_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_y |-> (cnt_y != '0));

    p_push_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && in_x && cnt_x < CW'(DEPTH)) |=> (cnt_x == $past(cnt_x) + 1'b1));

    p_pop_shrinks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_x && cnt_x != '0) |=> (cnt_x == $past(cnt_x) - 1'b1));

    p_empty_pop_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_x && cnt_x == '0) |=> (rdata == '0 && cnt_x == '0));

    p_full_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && in_x && cnt_x == CW'(DEPTH)) |=> (ovf_x && cnt_x == CW'(DEPTH)));

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_x && !(we && addr == CTRL_ADDR && !req_id)) |=> ovf_x);
endmodule

bind notif_queue_unit nq_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .WIN_BYTES(WIN_BYTES),
    .X_BASE(X_BASE), .POP_ADDR(POP_ADDR), .CTRL_ADDR(CTRL_ADDR)
) u_nq_checker (
    .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .re(re), .req_id(req_id),
    .rdata(rdata), .irq_x(irq_x), .irq_y(irq_y), .ovf_x(ovf_x),
    .cnt_x(cnt_x), .cnt_y(cnt_y)
);

// File: tb/tb_notif_queue_unit.sv
// Directed bench: one task per scenario, each checking its own results.
// Inputs change on falling edges; results are sampled on the next falling edge.
module tb_notif_queue_unit;
    localparam logic [15:0] XB = 16'h1000;
    localparam logic [15:0] YB = 16'h1080;
    localparam logic [15:0] POP = 16'h2000;
    localparam logic [15:0] CTL = 16'h2004;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic        re = 1'b0;
    logic        req_id = 1'b0;
    logic [31:0] rdata;
    logic        irq_x, irq_y, ovf_x, ovf_y, mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    notif_queue_unit dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we),
        .re(re), .req_id(req_id), .rdata(rdata), .irq_x(irq_x), .irq_y(irq_y),
        .ovf_x(ovf_x), .ovf_y(ovf_y), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [31:0] d, input logic id);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1; req_id = id;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic bus_rd(input logic [15:0] a, input logic id, output logic [31:0] d);
        @(negedge clk);
        addr = a; re = 1'b1; req_id = id;
        @(negedge clk);
        re = 1'b0;
        d = rdata;
    endtask

    task automatic t_reset();
        chk("R1 irq_x", 32'(irq_x), 0);
        chk("R1 irq_y", 32'(irq_y), 0);
        chk("R1 ovf_x", 32'(ovf_x), 0);
        chk("R1 ovf_y", 32'(ovf_y), 0);
        chk("R1 rdata", rdata, 0);
    endtask

    task automatic t_window();
        logic [31:0] d;
        bus_wr(XB, 32'hA000_0001, 1'b1);
        bus_wr(XB + 16'd127, 32'h5123_4567, 1'b1);
        bus_wr(XB - 16'd4, 32'hF000_0000, 1'b1);
        bus_wr(16'h1100, 32'hE000_0000, 1'b0);
        bus_rd(POP, 1'b0, d); chk("R2 first byte of X window", d, 32'hA);
        bus_rd(POP, 1'b0, d); chk("R2 last byte of X window", d, 32'h5);
        bus_rd(POP, 1'b0, d); chk("R2 outside writes ignored", d, 0);
        bus_rd(POP, 1'b1, d); chk("R2 Y empty after outside writes", d, 0);
    endtask

    task automatic t_order();
        logic [31:0] d;
        bus_wr(YB + 16'd64, 32'h3000_0000, 1'b0);
        bus_wr(YB,          32'h9000_0000, 1'b0);
        bus_wr(YB + 16'd8,  32'h1000_0000, 1'b1);
        bus_wr(YB + 16'd64, 32'hC000_0000, 1'b0);
        bus_rd(POP, 1'b1, d); chk("R3 order 0", d, 32'h3);
        bus_rd(POP, 1'b1, d); chk("R3 order 1", d, 32'h9);
        bus_rd(POP, 1'b1, d); chk("R3 order 2", d, 32'h1);
        bus_rd(POP, 1'b1, d); chk("R3 order 3", d, 32'hC);
    endtask

    task automatic t_steer();
        logic [31:0] d;
        bus_wr(XB + 16'd4, 32'h7000_0000, 1'b1);
        bus_wr(YB + 16'd4, 32'h2000_0000, 1'b0);
        bus_rd(POP, 1'b1, d); chk("R4 Y requester gets Y", d, 32'h2);
        bus_rd(POP, 1'b1, d); chk("R4 Y drained", d, 0);
        bus_rd(POP, 1'b0, d); chk("R4 X untouched by Y pop", d, 32'h7);
    endtask

    task automatic t_empty();
        logic [31:0] d;
        bus_rd(POP, 1'b0, d); chk("R5 empty pop returns 0", d, 0);
        bus_wr(XB, 32'h6000_0000, 1'b0);
        bus_rd(POP, 1'b0, d); chk("R5 queue intact after empty pop", d, 32'h6);
    endtask

    task automatic t_other_read();
        logic [31:0] d;
        bus_wr(XB, 32'hB000_0000, 1'b0);
        bus_rd(XB, 1'b0, d);  chk("R10 non-pop read returns 0", d, 0);
        bus_rd(CTL, 1'b0, d); chk("R10 control read returns 0", d, 0);
        bus_rd(POP, 1'b0, d); chk("R10 entry kept", d, 32'hB);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        bus_wr(XB, 32'h4000_0000, 1'b1);
        chk("R6 masked irq_x stays low", 32'(irq_x), 0);
        bus_wr(CTL, 32'h1, 1'b0);
        chk("R7 enable X raises irq_x", 32'(irq_x), 1);
        chk("R7 Y enable untouched", 32'(irq_y), 0);
        bus_wr(CTL, 32'h1, 1'b1);
        chk("R6 irq_y low while Y empty", 32'(irq_y), 0);
        bus_wr(YB, 32'h8000_0000, 1'b0);
        chk("R6 irq_y rises on push", 32'(irq_y), 1);
        bus_rd(POP, 1'b0, d);
        chk("R6 irq_x falls on last pop", 32'(irq_x), 0);
        bus_rd(POP, 1'b1, d);
        chk("R6 irq_y falls on last pop", 32'(irq_y), 0);
        bus_wr(CTL, 32'h0, 1'b0);
        bus_wr(XB, 32'h1000_0000, 1'b0);
        chk("R7 disable masks irq_x", 32'(irq_x), 0);
        bus_rd(POP, 1'b0, d);
    endtask

    task automatic t_overflow();
        logic [31:0] d;
        for (int i = 0; i < 64; i++) bus_wr(XB + 16'(4 * (i % 32)), {4'(i), 28'h0}, 1'b1);
        chk("R8 no overflow at 64 entries", 32'(ovf_x), 0);
        bus_wr(XB, 32'hD000_0000, 1'b1);
        chk("R8 overflow set on 65th write", 32'(ovf_x), 1);
        chk("R8 Y flag unaffected", 32'(ovf_y), 0);
        for (int i = 0; i < 64; i++) begin
            bus_rd(POP, 1'b0, d);
            chk("R8 stored entry", d, 32'(i % 16));
        end
        bus_rd(POP, 1'b0, d); chk("R8 dropped entry absent", d, 0);
        chk("R8 flag sticky", 32'(ovf_x), 1);
        bus_wr(CTL, 32'h2, 1'b1);
        chk("R7 Y clear leaves X flag", 32'(ovf_x), 1);
        bus_wr(CTL, 32'h2, 1'b0);
        chk("R7 clear X flag", 32'(ovf_x), 0);
    endtask

    task automatic t_pass();
        @(negedge clk);
        addr = 16'h3456; wdata = 32'hDEAD_BEEF; we = 1'b1;
        #1;
        chk("R9 mem_we", 32'(mem_we), 1);
        chk("R9 mem_addr", 32'(mem_addr), 32'h3456);
        chk("R9 mem_wdata", mem_wdata, 32'hDEAD_BEEF);
        @(negedge clk);
        we = 1'b0;
        #1;
        chk("R9 mem_we low", 32'(mem_we), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_window();
        t_order();
        t_steer();
        t_empty();
        t_other_read();
        t_irq();
        t_overflow();
        t_pass();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule